// File: doc/BRIEF.md
# Sticky Right Shifter for Fixed-Point Word Pairs

This block shifts a two-word fixed-point quantity to the right by an unsigned distance of any size. The upper word is the integer part and the lower word is the fraction part, with the binary point between them. The block returns the shifted integer word and a 64-bit extra word. The top bit of the extra word is the guard bit: the last bit that was shifted out. The other 63 bits of the extra word are nonzero exactly when some other nonzero bit was lost.

A floating-point datapath uses this block to align significands before an add or before conversion. Its downstream rounding logic reads both the guard position and a sticky indication from the extra word. The shift distance is not reduced modulo any width, so a very large count flushes the value into a single sticky bit.

When the `REG_OUT` parameter is set (the default), a register stage with an asynchronous active-low reset follows the combinational result. With `REG_OUT` cleared, the outputs follow the inputs directly.

Top module: `xshift_sticky`

## Requirements
- R1: A count of 0 gives `int_o` equal to `int_i` and `ext_o` equal to `frac_i`.
- R2: For a count c from 1 to 63, `int_o` equals `int_i` logically shifted right by c.
- R3: For a count c from 1 to 63, `ext_o` equals `int_i` shifted left by 64-c, with bit 0 ORed with the OR-reduction of `frac_i`.
- R4: A count of exactly 64 gives `int_o` of zero and `ext_o` equal to `int_i` with bit 0 ORed with the OR-reduction of `frac_i`.
- R5: For any count from 65 to 127, `int_o` is zero. In `ext_o`, bits 63..1 are zero and bit 0 is 1 exactly when `int_i` or `frac_i` is nonzero.
- R6: For a count c from 1 to 64, bit 63 of `ext_o` equals bit c-1 of `int_i`, which is the last bit shifted out.
- R7: For a count c from 1 to 64, bits 62..0 of `ext_o` are all zero exactly when `frac_i` is zero and bits c-2..0 of `int_i` are zero.
- R8: Counts of 128 and above, up to 65535, behave as in R5. This includes counts whose low seven bits alone would encode a small shift, so the count never wraps.
- R9: With `REG_OUT` set, results appear at the outputs one clock edge after the inputs are sampled. While `rst_ni` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| int_i | input | 64 | Integer word, above the binary point |
| frac_i | input | 64 | Fraction word, below the binary point |
| cnt_i | input | 16 | Unsigned right shift distance |
| int_o | output | 64 | Shifted integer word |
| ext_o | output | 64 | Extra word: guard bit in bit 63, sticky information in bits 62..0 |

## Verification
The design has only two kinds of internal state: which range the count falls into, and the state of each barrel stage. Errors in either show up at the ports on the next edge as a wrong `int_o` or `ext_o`.

- A wrong range decode appears as a flushed word where a shifted one was expected, or the reverse. The counts 0, 64, 65, 128 and values with large upper bits are aimed at these borders.
- A faulty barrel stage corrupts every count that uses that stage's bit. The guard-bit and sticky checks catch it, even when the fraction word is zero and the integer word is sparse.

// File: rtl/xshift_pkg.sv
`timescale 1ns/1ps
package xshift_pkg;
  typedef enum logic [1:0] {
    CLS_PASS  = 2'd0,
    CLS_SHIFT = 2'd1,
    CLS_FLUSH = 2'd2
  } cnt_cls_e;
endpackage

// File: rtl/xshift_decode.sv
`timescale 1ns/1ps
module xshift_decode
  import xshift_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 16,
  parameter int SH_W   = $clog2(WORD_W) + 1
) (
  input  logic [CNT_W-1:0] cnt_i,
  output cnt_cls_e         cls_o,
  output logic [SH_W-1:0]  amt_o
);
  // full-width compare: no modulo on the count
  always_comb begin
    if (cnt_i == '0)                  cls_o = CLS_PASS;
    else if (cnt_i > CNT_W'(WORD_W))  cls_o = CLS_FLUSH;
    else                              cls_o = CLS_SHIFT;
  end

  assign amt_o = cnt_i[SH_W-1:0];
endmodule

// File: rtl/xshift_barrel.sv
`timescale 1ns/1ps
module xshift_barrel #(
  parameter int WORD_W = 64,
  parameter int SH_W   = $clog2(WORD_W) + 1
) (
  input  logic [WORD_W-1:0] hi_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [WORD_W-1:0] hi_o,
  output logic [WORD_W-1:0] lo_o
);
  localparam int DW = 2 * WORD_W;

  logic [DW-1:0] stg [SH_W+1];

  // integer word over an empty low word; shifted-out bits land in the low word
  assign stg[0] = {hi_i, {WORD_W{1'b0}}};

  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    assign stg[g+1] = amt_i[g] ? (stg[g] >> (1 << g)) : stg[g];
  end

  assign hi_o = stg[SH_W][DW-1:WORD_W];
  assign lo_o = stg[SH_W][WORD_W-1:0];
endmodule

// File: rtl/xshift_sticky.sv
`timescale 1ns/1ps
module xshift_sticky
  import xshift_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int CNT_W   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] int_i,
  input  logic [WORD_W-1:0] frac_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [WORD_W-1:0] int_o,
  output logic [WORD_W-1:0] ext_o
);
  localparam int SH_W = $clog2(WORD_W) + 1;

  cnt_cls_e          cls;
  logic [SH_W-1:0]   amt;
  logic [WORD_W-1:0] bar_hi, bar_lo;
  logic [WORD_W-1:0] nxt_int, nxt_ext;
  logic              frac_nz, int_nz;

  assign frac_nz = |frac_i;
  assign int_nz  = |int_i;

  xshift_decode #(.WORD_W(WORD_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_decode (
    .cnt_i (cnt_i),
    .cls_o (cls),
    .amt_o (amt)
  );

  xshift_barrel #(.WORD_W(WORD_W), .SH_W(SH_W)) u_barrel (
    .hi_i  (int_i),
    .amt_i (amt),
    .hi_o  (bar_hi),
    .lo_o  (bar_lo)
  );

  always_comb begin
    unique case (cls)
      CLS_PASS: begin
        nxt_int = int_i;
        nxt_ext = frac_i;
      end
      CLS_SHIFT: begin
        nxt_int = bar_hi;
        nxt_ext = bar_lo | {{(WORD_W-1){1'b0}}, frac_nz};
      end
      default: begin
        nxt_int = '0;
        nxt_ext = {{(WORD_W-1){1'b0}}, int_nz | frac_nz};
      end
    endcase
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        int_o <= '0;
        ext_o <= '0;
      end else begin
        int_o <= nxt_int;
        ext_o <= nxt_ext;
      end
    end
  end else begin : g_comb
    assign int_o = nxt_int;
    assign ext_o = nxt_ext;
  end
endmodule

// File: rtl/xshift_sticky_chk.sv
`timescale 1ns/1ps
module xshift_sticky_chk #(
  parameter int WORD_W  = 64,
  parameter int CNT_W   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] int_i,
  input logic [WORD_W-1:0] frac_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [WORD_W-1:0] int_o,
  input logic [WORD_W-1:0] ext_o
);
  logic              vld_d;
  logic [WORD_W-1:0] int_d, frac_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              low_lost;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_d  <= 1'b0;
        int_d  <= '0;
        frac_d <= '0;
        cnt_d  <= '0;
      end else begin
        vld_d  <= 1'b1;
        int_d  <= int_i;
        frac_d <= frac_i;
        cnt_d  <= cnt_i;
      end
    end
  end else begin : g_now
    assign vld_d  = 1'b1;
    assign int_d  = int_i;
    assign frac_d = frac_i;
    assign cnt_d  = cnt_i;
  end

  // earlier lost bits of the integer word, below the guard position
  assign low_lost = (cnt_d > CNT_W'(1)) &&
                    ((int_d & ((WORD_W'(1) << (cnt_d - CNT_W'(1))) - WORD_W'(1))) != '0);

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_d && cnt_d == '0) |-> (int_o == int_d && ext_o == frac_d)); // R1

  AST_INT_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_d && cnt_d != '0 && cnt_d < CNT_W'(WORD_W)) |-> (int_o == (int_d >> cnt_d))); // R2

  AST_INT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_d && cnt_d >= CNT_W'(WORD_W)) |-> (int_o == '0)); // R4

  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_d && cnt_d > CNT_W'(WORD_W)) |->
      (ext_o == {{(WORD_W-1){1'b0}}, (int_d != '0) || (frac_d != '0)})); // R5

  AST_GUARD_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_d && cnt_d != '0 && cnt_d <= CNT_W'(WORD_W)) |->
      (ext_o[WORD_W-1] == int_d[cnt_d - CNT_W'(1)])); // R6

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_d && cnt_d != '0 && cnt_d <= CNT_W'(WORD_W)) |->
      ((ext_o[WORD_W-2:0] != '0) == ((frac_d != '0) || low_lost))); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    (REG_OUT && !rst_ni) |-> (int_o == '0 && ext_o == '0)); // R9
endmodule

bind xshift_sticky xshift_sticky_chk #(
  .WORD_W (WORD_W),
  .CNT_W  (CNT_W),
  .REG_OUT(REG_OUT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .int_i  (int_i),
  .frac_i (frac_i),
  .cnt_i  (cnt_i),
  .int_o  (int_o),
  .ext_o  (ext_o)
);

// File: tb/xshift_sticky_bench.sv
`timescale 1ns/1ps
module xshift_sticky_bench;
  logic        clk_i  = 1'b0;
  logic        rst_ni = 1'b1;
  logic [63:0] int_i  = '0;
  logic [63:0] frac_i = '0;
  logic [15:0] cnt_i  = '0;
  logic [63:0] int_o, ext_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  xshift_sticky u_xshift_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .int_i  (int_i),
    .frac_i (frac_i),
    .cnt_i  (cnt_i),
    .int_o  (int_o),
    .ext_o  (ext_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  // behavioural reference: bit-by-bit shift with an OR-accumulated lost flag
  task automatic model(input logic [63:0] a, input logic [63:0] f, input logic [15:0] c,
                       output logic [63:0] zi, output logic [63:0] ze);
    logic [127:0] w;
    logic lost;
    int n;
    w    = {a, 64'd0};
    lost = |f;
    n    = (c > 16'd130) ? 130 : int'(c);
    for (int k = 0; k < n; k++) begin
      lost = lost | w[0];
      w    = w >> 1;
    end
    if (c == 16'd0) begin
      zi = a; ze = f;
    end else if (c <= 16'd64) begin
      zi = w[127:64]; ze = w[63:0] | {63'd0, lost};
    end else begin
      zi = '0; ze = {63'd0, lost | (|w)};
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] f, input logic [15:0] c);
    logic [63:0] ei, ee;
    string ti, te;
    logic guard, stk;
    model(a, f, c, ei, ee);
    if (c == 16'd0)       begin ti = "R1"; te = "R1"; end
    else if (c < 16'd64)  begin ti = "R2"; te = "R3"; end
    else if (c == 16'd64) begin ti = "R4"; te = "R4"; end
    else if (c < 16'd128) begin ti = "R5"; te = "R5"; end
    else                  begin ti = "R8"; te = "R8"; end
    int_i = a; frac_i = f; cnt_i = c;
    @(negedge clk_i);
    chk(ti, "int_o", int_o, ei);
    chk(te, "ext_o", ext_o, ee);
    if (c != 16'd0 && c <= 16'd64) begin
      guard = a[c-16'd1];
      stk = (|f) || (c > 16'd1 && ((a & ((64'd1 << (c - 16'd1)) - 64'd1)) != 64'd0));
      chk("R6", "guard", {63'd0, ext_o[63]}, {63'd0, guard});
      chk("R7", "sticky", {63'd0, |ext_o[62:0]}, {63'd0, stk});
    end
  endtask

  initial begin
    #5 rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R9", "reset int_o", int_o, 64'd0);
    chk("R9", "reset ext_o", ext_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 latency: new inputs not visible before the next edge
    int_i = 64'hFFFF_0000_1234_5678; frac_i = 64'd1; cnt_i = 16'd4;
    #1 chk("R9", "latency int_o", int_o, 64'd0);
    chk("R9", "latency ext_o", ext_o, 64'd0);
    @(negedge clk_i);

    apply(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 16'd0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'd1);
    apply(64'h8000_0000_0000_0001, 64'd0, 16'd1);
    apply(64'h8000_0000_0000_0000, 64'd5, 16'd63);
    apply(64'h0000_0100_0000_0000, 64'd0, 16'd41);
    apply(64'h0000_0100_0000_0000, 64'd0, 16'd40);
    apply(64'h0000_0100_0000_0000, 64'd0, 16'd42);
    apply(64'hDEAD_BEEF_CAFE_F00D, 64'd0, 16'd64);
    apply(64'h0000_0000_0000_0002, 64'h10, 16'd64);
    apply(64'd0, 64'd0, 16'd65);
    apply(64'd0, 64'h1, 16'd65);
    apply(64'h8000_0000_0000_0000, 64'd0, 16'd127);
    apply(64'd1, 64'd0, 16'd128);
    apply(64'd0, 64'd0, 16'd128);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0100);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h8040);
    apply(64'd0, 64'd0, 16'hFFFF);
    apply(64'h4, 64'd0, 16'hFFFF);

    // R9 reset mid-run clears live outputs
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'd0);
    rst_ni = 1'b0;
    #1 chk("R9", "mid reset int_o", int_o, 64'd0);
    chk("R9", "mid reset ext_o", ext_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, f;
      logic [15:0] c;
      a = {$urandom, $urandom};
      f = (i % 3 == 0) ? 64'd0 : {$urandom, $urandom};
      if (i % 5 == 0) a = a & 64'h0000_0000_0000_F00F;
      c = (i % 2 == 1) ? 16'($urandom_range(0, 70)) : 16'($urandom);
      apply(a, f, c);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule